// File: doc/BRIEF.md
# Banked GPIO Controller with Set/Clear Access

This block is a memory-mapped general-purpose I/O controller that serves several banks of 32 pins each (four by default) behind one register window. Each bank keeps its own output latch, direction mask, rising and falling edge enables, pending-edge status and two spare storage words. Software never overwrites the direction, output or edge-enable words directly. It writes a mask to a dedicated set register or to a dedicated clear register, and only the pins whose mask bit is 1 change. Several agents can therefore own disjoint pins of one bank without a read-modify-write race.

Every pin input passes through a two-flop synchronizer. The controller compares each pin's level with its value one clock earlier and records enabled transitions in a write-one-to-clear status word. Each bank drives an interrupt line that is high while any of its status bits is set. A simple single-cycle register bus gives access. Writes take effect at the clock edge where `bus_we` is high. Read data appears on `bus_rdata` one clock after `bus_re` and holds until the next read.

Top module: `gpb_top`

## Requirements
- R1: After reset every bank has direction 0 (all inputs), output latch 0, rising and falling enables 0, status 0, spare words 0, all `irq` lines low, and `bus_rdata` 0.
- R2: A write to bank offset 0x18 sets the output latch bits whose mask bit is 1. A write to offset 0x24 clears them. Other bits are unchanged. `pin_out` always shows the latch.
- R3: A write to offset 0x54 sets direction bits and a write to offset 0x60 clears them, with masked bits only affected. Offset 0x0C reads the direction, where 1 means output. `pin_oe` equals the direction.
- R4: Offset 0x00 reads the pin level. For an output pin this is the latch bit. For an input pin it is `pin_in` after two synchronizing flops.
- R5: Offsets 0x6C/0x78 set/clear the rising enables, read back at 0x30. Offsets 0x84/0x90 set/clear the falling enables, read back at 0x3C.
- R6: A level change from 0 to 1 on a pin with its rising enable set, or from 1 to 0 with its falling enable set, sets that pin's bit in the status word at offset 0x48. For an input pin this happens on the third clock edge after `pin_in` changes. A transition whose enable is clear leaves the status unchanged.
- R7: Writing a mask to offset 0x48 clears the status bits written as 1 and leaves the others. If a new edge on a pin arrives at the same clock edge as the clear of that pin's bit, the bit stays set.
- R8: `irq[b]` is high exactly while any status bit of bank b is set.
- R9: All set and clear offsets (0x18, 0x24, 0x54, 0x60, 0x6C, 0x78, 0x84, 0x90) read as zero. Offsets outside the fifteen listed ones read as zero and writes to them change nothing.
- R10: Bank b occupies addresses b*0x100 + offset, and a write to one bank changes no state of another bank.
- R11: Offsets 0x9C and 0xA8 are plain 32-bit storage that reads back the last value written and affects no pin, enable or status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 10 | Bank index in bits 9:8, register offset in bits 7:0 |
| bus_wdata | input | 32 | Write mask or data |
| bus_rdata | output | 32 | Read data, valid one clock after `bus_re` |
| pin_in | input | 128 | Asynchronous pin inputs, bank b at bits 32b+31:32b |
| pin_out | output | 128 | Output latch of every pin |
| pin_oe | output | 128 | Output enable (direction) of every pin |
| irq | output | 4 | One interrupt line per bank |

## Verification
Set and clear masks are applied with overlapping and disjoint bit patterns so that a design that overwrites the whole word instead of merging shows a wrong readback. Pins change with only one of the two edge enables set, and with both set, which separates rising, falling and disabled transitions. A status clear is timed to land on the same edge as a new transition, which distinguishes edge-wins from clear-wins priority. Writes to one bank followed by readbacks of the others, and writes to the spare words, show whether any state leaks across banks or registers.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int unsigned NPIN  = 32;
    localparam int unsigned OFF_W = 8;

    typedef logic [NPIN-1:0] pin_vec_t;

    typedef enum logic [OFF_W-1:0] {
        OFF_LEVEL    = 8'h00,
        OFF_DIR      = 8'h0C,
        OFF_OUT_SET  = 8'h18,
        OFF_OUT_CLR  = 8'h24,
        OFF_RISE     = 8'h30,
        OFF_FALL     = 8'h3C,
        OFF_STAT     = 8'h48,
        OFF_DIR_SET  = 8'h54,
        OFF_DIR_CLR  = 8'h60,
        OFF_RISE_SET = 8'h6C,
        OFF_RISE_CLR = 8'h78,
        OFF_FALL_SET = 8'h84,
        OFF_FALL_CLR = 8'h90,
        OFF_SPARE_A  = 8'h9C,
        OFF_SPARE_B  = 8'hA8
    } reg_off_e;

    typedef struct packed {
        pin_vec_t dir;
        pin_vec_t out;
        pin_vec_t rise;
        pin_vec_t fall;
        pin_vec_t stat;
        pin_vec_t spare_a;
        pin_vec_t spare_b;
    } bank_state_t;

    // Offsets that accept a mask but have no readable content.
    function automatic logic is_mask_only(input logic [OFF_W-1:0] off);
        return (off == OFF_OUT_SET)  || (off == OFF_OUT_CLR)  ||
               (off == OFF_DIR_SET)  || (off == OFF_DIR_CLR)  ||
               (off == OFF_RISE_SET) || (off == OFF_RISE_CLR) ||
               (off == OFF_FALL_SET) || (off == OFF_FALL_CLR);
    endfunction

    // Merge a set mask and a clear mask into a current word.
    function automatic pin_vec_t merge_sc(input pin_vec_t cur, input pin_vec_t m,
                                          input logic do_set, input logic do_clr);
        pin_vec_t r;
        r = cur;
        if (do_set) r = r | m;
        if (do_clr) r = r & ~m;
        return r;
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  pin_vec_t         wdata,
    input  pin_vec_t         pin_sync,
    output pin_vec_t         rd_data,
    output pin_vec_t         pin_out,
    output pin_vec_t         pin_oe,
    output logic             irq
);
    bank_state_t st, st_n;
    pin_vec_t    level, level_q, edge_hit;

    assign level    = (st.dir & st.out) | (~st.dir & pin_sync);
    assign edge_hit = (level & ~level_q & st.rise) | (~level & level_q & st.fall);

    always_comb begin
        st_n = st;
        if (wr_en) begin
            case (off)
                OFF_OUT_SET:  st_n.out  = merge_sc(st.out,  wdata, 1'b1, 1'b0);
                OFF_OUT_CLR:  st_n.out  = merge_sc(st.out,  wdata, 1'b0, 1'b1);
                OFF_DIR_SET:  st_n.dir  = merge_sc(st.dir,  wdata, 1'b1, 1'b0);
                OFF_DIR_CLR:  st_n.dir  = merge_sc(st.dir,  wdata, 1'b0, 1'b1);
                OFF_RISE_SET: st_n.rise = merge_sc(st.rise, wdata, 1'b1, 1'b0);
                OFF_RISE_CLR: st_n.rise = merge_sc(st.rise, wdata, 1'b0, 1'b1);
                OFF_FALL_SET: st_n.fall = merge_sc(st.fall, wdata, 1'b1, 1'b0);
                OFF_FALL_CLR: st_n.fall = merge_sc(st.fall, wdata, 1'b0, 1'b1);
                OFF_SPARE_A:  st_n.spare_a = wdata;
                OFF_SPARE_B:  st_n.spare_b = wdata;
                default: ;
            endcase
        end
        // A fresh edge outranks a simultaneous clear.
        st_n.stat = merge_sc(st.stat, wdata, 1'b0, wr_en && (off == OFF_STAT)) | edge_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            level_q <= '0;
        end else begin
            st      <= st_n;
            level_q <= level;
        end
    end

    always_comb begin
        case (off)
            OFF_LEVEL:   rd_data = level;
            OFF_DIR:     rd_data = st.dir;
            OFF_RISE:    rd_data = st.rise;
            OFF_FALL:    rd_data = st.fall;
            OFF_STAT:    rd_data = st.stat;
            OFF_SPARE_A: rd_data = st.spare_a;
            OFF_SPARE_B: rd_data = st.spare_b;
            default:     rd_data = '0;
        endcase
    end

    assign pin_out = st.out;
    assign pin_oe  = st.dir;
    assign irq     = |st.stat;
endmodule

// File: rtl/gpb_top.sv
module gpb_top
    import gpb_pkg::*;
#(
    parameter int unsigned NBANK  = 4,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned ADDR_W = BANK_W + OFF_W,
    localparam int unsigned NALL   = NBANK * NPIN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NALL-1:0]   pin_in,
    output logic [NALL-1:0]   pin_out,
    output logic [NALL-1:0]   pin_oe,
    output logic [NBANK-1:0]  irq
);
    logic [BANK_W-1:0] bank_sel;
    logic [OFF_W-1:0]  off_sel;
    logic [NALL-1:0]   pin_sync;
    pin_vec_t          rd_vec [NBANK];

    assign bank_sel = bus_addr[ADDR_W-1:OFF_W];
    assign off_sel  = bus_addr[OFF_W-1:0];

    gpb_sync #(.W(NALL)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_in),
        .d_sync  (pin_sync)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpb_bank i_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bus_we && (bank_sel == BANK_W'(b))),
            .off      (off_sel),
            .wdata    (bus_wdata),
            .pin_sync (pin_sync[b*NPIN +: NPIN]),
            .rd_data  (rd_vec[b]),
            .pin_out  (pin_out[b*NPIN +: NPIN]),
            .pin_oe   (pin_oe[b*NPIN +: NPIN]),
            .irq      (irq[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rd_vec[bank_sel];
    end
endmodule

// File: rtl/gpb_chk.sv
module gpb_chk
    import gpb_pkg::*;
#(
    parameter int unsigned NBANK  = 4,
    localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int unsigned ADDR_W = BANK_W + OFF_W,
    localparam int unsigned NALL   = NBANK * NPIN
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic              bus_re,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPIN-1:0]   bus_rdata,
    input logic [NALL-1:0]   pin_out,
    input logic [NALL-1:0]   pin_oe,
    input logic [NBANK-1:0]  irq
);
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_out == '0 && pin_oe == '0 && irq == '0 && bus_rdata == '0));

    assert_out_needs_write_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_out) |-> $past(bus_we));

    assert_dir_needs_write_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(pin_oe) |-> $past(bus_we));

    assert_mask_reg_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_re) && is_mask_only($past(bus_addr[OFF_W-1:0]))) |-> bus_rdata == '0);

    for (genvar b = 0; b < NBANK; b++) begin : g_irq
        assert_irq_drop_by_clear_R8: assert property (@(posedge clk) disable iff (rst)
            $fell(irq[b]) |-> ($past(bus_we) &&
                               $past(bus_addr[ADDR_W-1:OFF_W]) == BANK_W'(b) &&
                               $past(bus_addr[OFF_W-1:0]) == OFF_STAT));
    end
endmodule

bind gpb_top gpb_chk #(.NBANK(NBANK)) i_gpb_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/test_gpb_top.sv
module test_gpb_top;
    localparam int NB = 4;
    localparam int NP = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_we = 1'b0, bus_re = 1'b0;
    logic [9:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NB*NP-1:0] pin_in = '0;
    logic [NB*NP-1:0] pin_out, pin_oe;
    logic [NB-1:0]   irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpb_top i_gpb_top (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Behavioural reference model.
    logic [31:0] m_dir[NB], m_out[NB], m_rise[NB], m_fall[NB], m_stat[NB];
    logic [31:0] m_spa[NB], m_spb[NB], m_s1[NB], m_s2[NB], m_prev[NB];
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_level(int b);
        return (m_dir[b] & m_out[b]) | (~m_dir[b] & m_s2[b]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NB; b++) begin
                m_dir[b] = 0; m_out[b] = 0; m_rise[b] = 0; m_fall[b] = 0; m_stat[b] = 0;
                m_spa[b] = 0; m_spb[b] = 0; m_s1[b] = 0; m_s2[b] = 0; m_prev[b] = 0;
            end
            m_rdata = 0;
        end else begin
            int wb, wo;
            logic [31:0] lv[NB];
            wb = int'(bus_addr[9:8]);
            wo = int'(bus_addr[7:0]);
            for (int b = 0; b < NB; b++) lv[b] = m_level(b);
            if (bus_re) begin
                case (wo)
                    'h00: m_rdata = lv[wb];
                    'h0C: m_rdata = m_dir[wb];
                    'h30: m_rdata = m_rise[wb];
                    'h3C: m_rdata = m_fall[wb];
                    'h48: m_rdata = m_stat[wb];
                    'h9C: m_rdata = m_spa[wb];
                    'hA8: m_rdata = m_spb[wb];
                    default: m_rdata = 0;
                endcase
            end
            for (int b = 0; b < NB; b++) begin
                logic [31:0] hit;
                hit = 0;
                for (int p = 0; p < NP; p++) begin
                    if (m_rise[b][p] && lv[b][p] && !m_prev[b][p]) hit[p] = 1'b1;
                    if (m_fall[b][p] && !lv[b][p] && m_prev[b][p]) hit[p] = 1'b1;
                end
                if (bus_we && wb == b && wo == 'h48) m_stat[b] = m_stat[b] & ~bus_wdata;
                m_stat[b] = m_stat[b] | hit;
                if (bus_we && wb == b) begin
                    case (wo)
                        'h18: m_out[b]  = m_out[b]  | bus_wdata;
                        'h24: m_out[b]  = m_out[b]  & ~bus_wdata;
                        'h54: m_dir[b]  = m_dir[b]  | bus_wdata;
                        'h60: m_dir[b]  = m_dir[b]  & ~bus_wdata;
                        'h6C: m_rise[b] = m_rise[b] | bus_wdata;
                        'h78: m_rise[b] = m_rise[b] & ~bus_wdata;
                        'h84: m_fall[b] = m_fall[b] | bus_wdata;
                        'h90: m_fall[b] = m_fall[b] & ~bus_wdata;
                        'h9C: m_spa[b]  = bus_wdata;
                        'hA8: m_spb[b]  = bus_wdata;
                        default: ;
                    endcase
                end
                m_prev[b] = lv[b];
                m_s2[b]   = m_s1[b];
                m_s1[b]   = pin_in[b*NP +: NP];
            end
        end
    end

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [127:0] eo, ed;
            logic [3:0] ei;
            for (int b = 0; b < NB; b++) begin
                eo[b*NP +: NP] = m_out[b];
                ed[b*NP +: NP] = m_dir[b];
                ei[b] = |m_stat[b];
            end
            chk("R2 pin_out vs model", pin_out, eo);
            chk("R3 pin_oe vs model", pin_oe, ed);
            chk("R8 irq vs model", {124'd0, irq}, {124'd0, ei});
            chk("R9 bus_rdata vs model", {96'd0, bus_rdata}, {96'd0, m_rdata});
        end
    end

    task automatic wr(logic [9:0] a, logic [31:0] d);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 0; bus_wdata = 0;
    endtask

    task automatic rd_chk(string tag, logic [9:0] a, logic [31:0] exp);
        bus_re = 1; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_re = 0;
        chk(tag, {96'd0, bus_rdata}, {96'd0, exp});
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 irq after reset", {124'd0, irq}, 128'd0);
        chk("R1 pin_oe after reset", pin_oe, 128'd0);
        rd_chk("R1 bank0 direction", 10'h00C, 0);
        rd_chk("R1 bank1 status", 10'h148, 0);
        rd_chk("R1 bank3 rise enables", 10'h330, 0);

        // R2 / R3 / R4 on bank 0
        wr(10'h054, 32'h0000FFFF);
        wr(10'h018, 32'h0000A5A5);
        wr(10'h024, 32'h00000005);
        rd_chk("R3 direction after set", 10'h00C, 32'h0000FFFF);
        chk("R2 latch after set then clear", {96'd0, pin_out[31:0]}, {96'd0, 32'h0000A5A0});
        rd_chk("R4 level of output pins", 10'h000, 32'h0000A5A0);
        rd_chk("R9 output-set reads zero", 10'h018, 0);
        rd_chk("R9 dir-clear reads zero", 10'h060, 0);
        rd_chk("R9 unlisted offset reads zero", 10'h0B4, 0);
        wr(10'h060, 32'h0000FF00);
        rd_chk("R3 direction after clear", 10'h00C, 32'h000000FF);
        pin_in[31:16] = 16'hF0F0;
        cyc(4);
        rd_chk("R4 mixed level", 10'h000, 32'hF0F000A0);

        // R5 enables on bank 1
        wr(10'h16C, 32'h1);
        wr(10'h184, 32'h3);
        rd_chk("R5 rise readback", 10'h130, 32'h1);
        rd_chk("R5 fall readback", 10'h13C, 32'h3);

        // R6 edges
        pin_in[33:32] = 2'b11;
        cyc(4);
        rd_chk("R6 only enabled rise recorded", 10'h148, 32'h1);
        chk("R8 irq bank1 only", {124'd0, irq}, {124'd0, 4'b0010});
        wr(10'h148, 32'h1);
        rd_chk("R7 clear by one", 10'h148, 0);
        chk("R8 irq low after clear", {124'd0, irq}, 128'd0);
        pin_in[33:32] = 2'b00;
        cyc(4);
        rd_chk("R6 both falls recorded", 10'h148, 32'h3);
        wr(10'h148, 32'h2);
        rd_chk("R7 partial clear", 10'h148, 32'h1);
        wr(10'h148, 32'h1);
        wr(10'h178, 32'h1);
        rd_chk("R5 rise cleared", 10'h130, 0);
        pin_in[32] = 1'b1;
        cyc(4);
        rd_chk("R6 disabled rise ignored", 10'h148, 0);

        // R7 edge and clear on the same edge: edge wins
        pin_in[32] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr(10'h148, 32'h1);
        rd_chk("R7 edge beats clear", 10'h148, 32'h1);
        wr(10'h148, 32'hFFFFFFFF);
        rd_chk("R7 full clear", 10'h148, 0);

        // R11 spare storage on bank 2
        wr(10'h29C, 32'h12345678);
        wr(10'h2A8, 32'hCAFEF00D);
        rd_chk("R11 spare A", 10'h29C, 32'h12345678);
        rd_chk("R11 spare B", 10'h2A8, 32'hCAFEF00D);
        rd_chk("R11 spare leaves direction", 10'h20C, 0);
        wr(10'h2B4, 32'hFFFFFFFF);
        rd_chk("R9 unlisted write ignored", 10'h20C, 0);

        // R10 bank independence
        wr(10'h354, 32'hFFFFFFFF);
        chk("R10 bank3 oe", {96'd0, pin_oe[127:96]}, {96'd0, 32'hFFFFFFFF});
        chk("R10 other banks oe", {32'd0, pin_oe[95:0]}, {32'd0, 96'h000000FF});
        rd_chk("R10 bank2 dir untouched", 10'h20C, 0);
        rd_chk("R10 bank0 dir untouched", 10'h00C, 32'h000000FF);
        cyc(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule